// File: doc/BRIEF.md
# Digital Supply Fault Detector

This block watches one supply channel after it has been digitised into an 8-bit code. In supply mode it compares that code against two programmable limits, a lower (undervoltage) code and an upper (overvoltage) code. It raises a fault on an undervoltage, an overvoltage, or either one (window), as configured. Once a fault is raised, a programmable hysteresis offset widens the good region, so a sample sitting on a limit does not make the output chatter.

A glitch qualifier sits between the raw comparison and the fault output. It counts pulses of a slow system tick, nominally one every 10 µs, and changes the output only after the new condition has held for the programmed number of ticks. A length of zero passes the comparison through on the next clock. In logic mode the thresholds are bypassed and the same qualifier conditions a raw digital input instead. Software configures the block through a simple write port.

Top module: `sfd_channel`

## Requirements
- R1: After reset the fault output is 0 and all configuration registers read as 0: lower limit 0, upper limit 0, hysteresis 0, undervoltage type, supply mode and filter length 0.
- R2: With fault type 0 (undervoltage) in supply mode, the raw condition is bad when sample < lower limit. A sample equal to the limit is good.
- R3: With fault type 1 (overvoltage), the raw condition is bad when sample > upper limit. A sample equal to the limit is good.
- R4: With fault type 2 or 3 (window), the raw condition is bad when either the undervoltage or the overvoltage condition holds.
- R5: With filter length L > 0, the fault output asserts at the clock edge that samples the L-th tick pulse during which the bad condition has held without a break. It does not assert earlier.
- R6: Any clock at which the raw condition agrees with the current output restarts the tick count.
- R7: With filter length 0, the output takes the raw condition on the next clock edge, whatever the tick input does.
- R8: While the fault is asserted, hysteresis H widens the good region. The undervoltage limit becomes min(lower+H, 255), and the sample is good when it is at or above that value. The overvoltage limit becomes max(upper−H, 0), and the sample is good when it is at or below that value. While no fault is asserted, the plain limits apply.
- R9: Deassertion follows the same qualifier. The output clears only after the hysteresis-adjusted good condition has held for L ticks.
- R10: In logic mode (control bit 2 = 1), the raw condition is the logic input (1 = fault). The sample, the limits and the hysteresis are ignored, and the filter still applies.
- R11: The register map is: address 0 lower limit, address 1 upper limit, address 2 hysteresis, address 3 control. Control bits [1:0] hold the fault type, bit 2 the mode and bits [7:3] the filter length in ticks. A length above 10 acts as 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-clock pulse of the slow timing tick |
| sample | input | 8 | Digitised supply code |
| logic_in | input | 1 | Raw digital input used in logic mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| fault | output | 1 | Qualified fault output |

## Verification
On every cycle the assertions check three things about the qualifier. The tick count stays bounded. It restarts whenever the raw condition agrees with the output. The output changes only on a tick, or on the next clock when the length is zero. The bench scenarios are the only place where the comparison itself is shown to be right. They cover the limit-equal boundaries, the type selection, the hysteresis release points including the saturated limit, the bypass in logic mode and the clamping of the filter length, since these depend on the configured values and not on any invariant that holds on every cycle.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

    localparam int CODE_W  = 8;
    localparam int LEN_W   = 5;
    localparam int LEN_MAX = 10;
    localparam int ADDR_W  = 2;

    typedef enum logic [1:0] {
        FT_UNDER = 2'd0,
        FT_OVER  = 2'd1,
        FT_WIN   = 2'd2,
        FT_WIN_B = 2'd3
    } ftype_e;

    typedef struct packed {
        logic [CODE_W-1:0] lo_lim;
        logic [CODE_W-1:0] hi_lim;
        logic [CODE_W-1:0] hyst;
        ftype_e            ftype;
        logic              logic_mode;
        logic [LEN_W-1:0]  flen;
    } cfg_t;

endpackage

// File: rtl/sfd_cfg.sv
module sfd_cfg
    import sfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CODE_W-1:0] wdata,
    output cfg_t              cfg
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (addr)
                2'd0: cfg_d.lo_lim = wdata;
                2'd1: cfg_d.hi_lim = wdata;
                2'd2: cfg_d.hyst   = wdata;
                default: begin
                    cfg_d.ftype      = ftype_e'(wdata[1:0]);
                    cfg_d.logic_mode = wdata[2];
                    cfg_d.flen       = wdata[3 +: LEN_W];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/sfd_compare.sv
module sfd_compare
    import sfd_pkg::*;
(
    input  logic [CODE_W-1:0] sample,
    input  logic              logic_in,
    input  cfg_t              cfg,
    input  logic              fault_q,
    output logic              raw_bad
);

    logic [CODE_W:0]   lo_sum;
    logic [CODE_W-1:0] lo_eff;
    logic [CODE_W-1:0] hi_eff;
    logic              under;
    logic              over;

    always_comb begin
        lo_sum = {1'b0, cfg.lo_lim} + {1'b0, cfg.hyst};
        if (fault_q) begin
            lo_eff = lo_sum[CODE_W] ? '1 : lo_sum[CODE_W-1:0];
            hi_eff = (cfg.hyst > cfg.hi_lim) ? '0 : cfg.hi_lim - cfg.hyst;
        end else begin
            lo_eff = cfg.lo_lim;
            hi_eff = cfg.hi_lim;
        end
        under = sample < lo_eff;
        over  = sample > hi_eff;
        if (cfg.logic_mode) begin
            raw_bad = logic_in;
        end else begin
            case (cfg.ftype)
                FT_UNDER: raw_bad = under;
                FT_OVER:  raw_bad = over;
                default:  raw_bad = under | over;
            endcase
        end
    end

endmodule

// File: rtl/sfd_filter.sv
module sfd_filter
    import sfd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             raw_bad,
    input  logic [LEN_W-1:0] flen,
    output logic             fault_q
);

    typedef struct packed {
        logic             fault;
        logic [LEN_W-1:0] cnt;
    } filt_t;

    filt_t st_d, st_q;
    logic [LEN_W-1:0] len_eff;
    logic [LEN_W:0]   cnt_inc;

    always_comb begin
        len_eff = (flen > LEN_W'(LEN_MAX)) ? LEN_W'(LEN_MAX) : flen;
        cnt_inc = {1'b0, st_q.cnt} + 1'b1;
        st_d    = st_q;
        if (raw_bad != st_q.fault) begin
            if (len_eff == '0) begin
                st_d.fault = raw_bad;
                st_d.cnt   = '0;
            end else if (tick) begin
                if (cnt_inc >= {1'b0, len_eff}) begin
                    st_d.fault = raw_bad;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = cnt_inc[LEN_W-1:0];
                end
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fault_q = st_q.fault;

    a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LEN_W'(LEN_MAX));

    a_r6_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_bad == st_q.fault) |=> (st_q.cnt == '0));

    a_r5_tick_paced: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.fault) |-> $past(len_eff == '0 || tick));

    a_r7_zero_len_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (len_eff == '0 && raw_bad != st_q.fault) |=> (st_q.fault == $past(raw_bad)));

endmodule

// File: rtl/sfd_channel.sv
module sfd_channel
    import sfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CODE_W-1:0] sample,
    input  logic              logic_in,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CODE_W-1:0] cfg_wdata,
    output logic              fault
);

    cfg_t cfg;
    logic raw_bad;
    logic fault_q;

    sfd_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    sfd_compare u_cmp (
        .sample   (sample),
        .logic_in (logic_in),
        .cfg      (cfg),
        .fault_q  (fault_q),
        .raw_bad  (raw_bad)
    );

    sfd_filter u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .raw_bad (raw_bad),
        .flen    (cfg.flen),
        .fault_q (fault_q)
    );

    assign fault = fault_q;

    a_r10_logic_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.logic_mode && cfg.flen == '0 && !cfg_we) |=> (fault == $past(logic_in)));

endmodule

// File: tb/tb_sfd_channel.sv
module tb_sfd_channel;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] sample = 8'd150;
    logic       logic_in = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic       fault;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    bit    exp_q[$];
    string tag_q[$];
    event  mon_ev;

    always #5 clk = ~clk;

    sfd_channel dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .sample    (sample),
        .logic_in  (logic_in),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .fault     (fault)
    );

    // Monitor: pops expected items and compares against the output
    initial begin
        forever begin
            @(mon_ev);
            #1;
            while (exp_q.size() > 0) begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (fault !== e) begin
                    n_bad++;
                    $display("FAIL %s: fault=%0b expected=%0b", t, fault, e);
                end
            end
        end
    end

    task automatic expect_fault(input string t, input bit e);
        exp_q.push_back(e);
        tag_q.push_back(t);
        -> mon_ev;
        #2;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic set_s(input logic [7:0] v);
        sample = v;
        cyc(1);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        expect_fault("R1 reset output", 1'b0);
        set_s(8'd0);
        expect_fault("R1 default limits give no fault", 1'b0);

        wr(2'd0, 8'd100);
        wr(2'd1, 8'd200);
        wr(2'd2, 8'd0);
        wr(2'd3, 8'h00);
        set_s(8'd150); expect_fault("R2 good sample", 1'b0);
        set_s(8'd100); expect_fault("R2 equal to lower limit", 1'b0);
        set_s(8'd99);  expect_fault("R2 below limit R7 len0", 1'b1);
        tick = 1'b1;
        set_s(8'd150); expect_fault("R7 clears next clock", 1'b0);
        tick = 1'b0;

        wr(2'd3, 8'h01);
        set_s(8'd50);  expect_fault("R3 low sample ignored in OV", 1'b0);
        set_s(8'd200); expect_fault("R3 equal to upper limit", 1'b0);
        set_s(8'd201); expect_fault("R3 above limit", 1'b1);
        set_s(8'd150); expect_fault("R3 back in range", 1'b0);

        wr(2'd3, 8'h02);
        set_s(8'd50);  expect_fault("R4 window low", 1'b1);
        set_s(8'd150); expect_fault("R4 window inside", 1'b0);
        set_s(8'd250); expect_fault("R4 window high", 1'b1);
        set_s(8'd150);
        wr(2'd3, 8'h03);
        set_s(8'd20);  expect_fault("R4 type 3 window low", 1'b1);
        set_s(8'd150); expect_fault("R4 type 3 inside", 1'b0);

        wr(2'd3, 8'h18);
        set_s(8'd50);
        cyc(5);        expect_fault("R5 no ticks no fault", 1'b0);
        pulse(1);      expect_fault("R5 after 1 tick", 1'b0);
        pulse(1);      expect_fault("R5 after 2 ticks", 1'b0);
        pulse(1);      expect_fault("R5 after 3 ticks", 1'b1);
        set_s(8'd150);
        pulse(2);      expect_fault("R9 held after 2 good ticks", 1'b1);
        pulse(1);      expect_fault("R9 cleared after 3 good ticks", 1'b0);

        set_s(8'd50);
        pulse(2);
        set_s(8'd150);
        set_s(8'd50);
        pulse(2);      expect_fault("R6 count restarted", 1'b0);
        pulse(1);      expect_fault("R6 asserts after fresh 3", 1'b1);
        set_s(8'd150);
        pulse(3);      expect_fault("R9 cleared again", 1'b0);

        wr(2'd3, 8'h00);
        wr(2'd2, 8'd10);
        set_s(8'd99);  expect_fault("R8 UV asserted", 1'b1);
        set_s(8'd105); expect_fault("R8 inside hysteresis band", 1'b1);
        set_s(8'd109); expect_fault("R8 just below release", 1'b1);
        set_s(8'd110); expect_fault("R8 released at lo+H", 1'b0);
        set_s(8'd105); expect_fault("R8 plain limit while good", 1'b0);
        wr(2'd3, 8'h01);
        set_s(8'd201); expect_fault("R8 OV asserted", 1'b1);
        set_s(8'd195); expect_fault("R8 OV in band", 1'b1);
        set_s(8'd190); expect_fault("R8 OV released at hi-H", 1'b0);
        wr(2'd3, 8'h00);
        wr(2'd0, 8'd250);
        set_s(8'd249); expect_fault("R8 high limit fault", 1'b1);
        set_s(8'd255); expect_fault("R8 saturated release", 1'b0);
        wr(2'd0, 8'd100);
        wr(2'd2, 8'd0);

        wr(2'd3, 8'h04);
        logic_in = 1'b0;
        set_s(8'd50);  expect_fault("R10 sample ignored", 1'b0);
        logic_in = 1'b1;
        cyc(1);        expect_fault("R10 logic high", 1'b1);
        sample = 8'd150;
        cyc(1);        expect_fault("R10 still follows input", 1'b1);
        logic_in = 1'b0;
        cyc(1);        expect_fault("R10 logic low", 1'b0);
        wr(2'd3, 8'h14);
        logic_in = 1'b1;
        pulse(1);      expect_fault("R10 filtered 1 tick", 1'b0);
        pulse(1);      expect_fault("R10 filtered 2 ticks", 1'b1);
        logic_in = 1'b0;
        pulse(2);      expect_fault("R10 filtered release", 1'b0);

        wr(2'd3, 8'hF8);
        set_s(8'd50);
        pulse(9);      expect_fault("R11 length clamp not yet", 1'b0);
        pulse(1);      expect_fault("R11 length clamped to 10", 1'b1);
        set_s(8'd150);
        pulse(10);     expect_fault("R11 clamp release", 1'b0);

        rst_n = 1'b0;
        cyc(1);
        rst_n = 1'b1;
        set_s(8'd0);   expect_fault("R1 re-reset clears config", 1'b0);

        cyc(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule